// File: doc/BRIEF.md
# OTG Line Status Tracker

This block keeps the 16-bit line status word that an OTG-capable USB controller reports to software. Single-cycle update strobes from the PHY and core side each carry a level, one for VBUS and one for the session. The block stores these levels as status flags and raises a one-cycle change event towards the parent interrupt controller. That event fires only when a VBUS report really flips the stored VBUS flag.

Session reports keep the session-valid and session-end flags as complements of each other and never raise an event. The remaining fields of the word are power/clock good, VBUS sense, ID role, host disconnect and line state. None of them has a source inside this block, so they read as zero. A zero ID-role bit means the host role, which is the state after reset. Software reads the word through a 32-bit read port with one cycle of latency.

Top module: `otg_line_tracker`

## Requirements
- R1: After reset the status word is all zeros, so bit 3 (ID role) = 0 reports the host role. `vbus_chg_evt` is low and `rd_data` is zero.
- R2: A VBUS update (`vbus_upd`=1) with `vbus_level`=1 sets bit 5 (VBUS valid) at that clock edge.
- R3: A VBUS update with `vbus_level`=0 clears bit 5 at that clock edge.
- R4: `vbus_chg_evt` is high for exactly the one cycle after the edge at which bit 5 toggles.
- R5: A VBUS update whose level equals the stored bit 5 leaves the word unchanged and keeps `vbus_chg_evt` low.
- R6: A session update (`sess_upd`=1) with `sess_level`=1 sets bit 6 (session valid) and clears bit 7 (session end). With `sess_level`=0 it clears bit 6 and sets bit 7. Bits 6 and 7 are never both 1.
- R7: A session update on its own never raises `vbus_chg_evt`.
- R8: A VBUS update and a session update in the same cycle are both applied. The VBUS change decision compares against bit 5 as it stood before that edge.
- R9: Bits 8, 4, 3, 2 and 1:0 of the word, bits 15:9, and `rd_data` bits 31:16 always read as zero.
- R10: `rd_data` takes the status word as it stood before the edge at which `rd_en`=1 is sampled. It holds its value while `rd_en`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbus_upd | input | 1 | Strobe: a VBUS level report is present |
| vbus_level | input | 1 | Reported VBUS-valid level |
| sess_upd | input | 1 | Strobe: a session level report is present |
| sess_level | input | 1 | Reported session-active level |
| rd_en | input | 1 | Read request for the status word |
| rd_data | output | 32 | Zero-extended status word, valid one cycle after `rd_en` |
| vbus_chg_evt | output | 1 | One-cycle pulse when the VBUS flag toggles |

## Verification
The bench builds the block with its defaults: a 16-bit status word and a 32-bit read port. With these values the zero-extension branch of the read path is in use, and the full word including the upper half is compared on every read. The directed cases cover a repeated VBUS level and a VBUS report combined with each session polarity. They also cover a read issued on the same edge as a VBUS toggle, which shows that the pre-update word is returned.

// File: rtl/otg_stat_pkg.sv
package otg_stat_pkg;

    // Bit positions inside the status word; software decodes these.
    localparam int unsigned LINE_LO_B    = 0;
    localparam int unsigned LINE_HI_B    = 1;
    localparam int unsigned HOST_DISC_B  = 2;
    localparam int unsigned ID_ROLE_B    = 3;
    localparam int unsigned VBUS_SENSE_B = 4;
    localparam int unsigned VBUS_OK_B    = 5;
    localparam int unsigned SESS_OK_B    = 6;
    localparam int unsigned SESS_OVER_B  = 7;
    localparam int unsigned PWR_CLK_B    = 8;

    // Lowest word width that holds every defined field.
    localparam int unsigned MIN_STAT_W   = PWR_CLK_B + 1;

    typedef struct packed {
        logic vbus;
        logic chg;
    } vbus_state_t;

    typedef struct packed {
        logic ok;
        logic over;
    } sess_state_t;

endpackage

// File: rtl/otg_vbus_track.sv
module otg_vbus_track
    import otg_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic level,
    output logic vbus_q,
    output logic chg_q
);

    vbus_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (upd && (level != st_q.vbus)) begin
            st_d.vbus = level;
            st_d.chg  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vbus_q = st_q.vbus;
    assign chg_q  = st_q.chg;

    // R2 / R3: a report lands in the flag at the next edge
    a_r2_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (vbus_q == $past(level)));

    // R4: an event is only seen together with a real toggle
    a_r4_chg_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q |-> (vbus_q != $past(vbus_q)));

    // R5: repeating the stored level stays quiet
    a_r5_quiet_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (level == vbus_q)) |=> !chg_q);

endmodule

// File: rtl/otg_sess_track.sv
module otg_sess_track
    import otg_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic level,
    output logic ok_q,
    output logic over_q
);

    sess_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd) begin
            st_d.ok   = level;
            st_d.over = !level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ok_q   = st_q.ok;
    assign over_q = st_q.over;

    // R6: valid and end are never set together
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_q && over_q));

    // R6: both flags follow the report at the next edge
    a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> ((ok_q == $past(level)) && (over_q == !$past(level))));

endmodule

// File: rtl/otg_line_tracker.sv
module otg_line_tracker
    import otg_stat_pkg::*;
#(
    parameter int unsigned STAT_W = 16,
    parameter int unsigned RD_W   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vbus_upd,
    input  logic            vbus_level,
    input  logic            sess_upd,
    input  logic            sess_level,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data,
    output logic            vbus_chg_evt
);

    localparam int unsigned PAD_W = (RD_W > STAT_W) ? (RD_W - STAT_W) : 0;

    typedef struct packed {
        logic [RD_W-1:0] data;
    } rd_state_t;

    logic              vbus_flag;
    logic              vbus_evt;
    logic              sess_ok;
    logic              sess_over;
    logic [STAT_W-1:0] stat_word;
    logic [RD_W-1:0]   rd_word;
    rd_state_t         rd_d, rd_q;

    otg_vbus_track u_vbus (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (vbus_upd),
        .level  (vbus_level),
        .vbus_q (vbus_flag),
        .chg_q  (vbus_evt)
    );

    otg_sess_track u_sess (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (sess_upd),
        .level  (sess_level),
        .ok_q   (sess_ok),
        .over_q (sess_over)
    );

    // Fields without a source inside this block stay at zero.
    always_comb begin
        stat_word              = '0;
        stat_word[VBUS_OK_B]   = vbus_flag;
        stat_word[SESS_OK_B]   = sess_ok;
        stat_word[SESS_OVER_B] = sess_over;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_word = {{PAD_W{1'b0}}, stat_word};
        end else begin : g_trunc
            assign rd_word = stat_word[RD_W-1:0];
        end
    endgenerate

    always_comb begin
        rd_d = rd_q;
        if (rd_en) rd_d.data = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data      = rd_q.data;
    assign vbus_chg_evt = vbus_evt;

    // R7: a lone session report never produces an event
    a_r7_sess_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (sess_upd && !vbus_upd) |=> !vbus_chg_evt);

    // R8: simultaneous reports are both applied
    a_r8_both_applied: assert property (@(posedge clk) disable iff (!rst_n)
        (vbus_upd && sess_upd) |=>
            ((vbus_flag == $past(vbus_level)) && (sess_ok == $past(sess_level))));

    // R10: a read returns the flags held before the sampling edge
    a_r10_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ((rd_data[VBUS_OK_B] == $past(vbus_flag)) &&
                   (rd_data[SESS_OK_B] == $past(sess_ok))));

    // R10: without a request the read register holds
    a_r10_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/sim_otg_line_tracker.sv
module sim_otg_line_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vbus_upd = 1'b0;
    logic        vbus_level = 1'b0;
    logic        sess_upd = 1'b0;
    logic        sess_level = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        vbus_chg_evt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Bench model of the status flags
    logic m_vbus = 1'b0;
    logic m_ok   = 1'b0;
    logic m_over = 1'b0;

    always #10 clk = ~clk;

    otg_line_tracker u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .vbus_upd     (vbus_upd),
        .vbus_level   (vbus_level),
        .sess_upd     (sess_upd),
        .sess_level   (sess_level),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .vbus_chg_evt (vbus_chg_evt)
    );

    function automatic logic [31:0] model_word();
        return {24'h0, m_over, m_ok, m_vbus, 5'h0};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Read the word through the port; rd_data is valid after one edge.
    task automatic read_check(input string tag);
        logic [31:0] exp;
        exp = model_word();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_data == exp, tag, rd_data, exp);
        check((rd_data & ~32'h0000_00E0) == 32'h0, "R9 unused bits zero",
              rd_data, rd_data & 32'h0000_00E0);
    endtask

    // Apply one cycle of reports, check the pulse and its end.
    task automatic apply(input bit ve, input bit vl, input bit se, input bit sl,
                         input string tag);
        bit exp_chg;
        exp_chg = ve && (vl != m_vbus);
        @(negedge clk);
        vbus_upd = ve; vbus_level = vl;
        sess_upd = se; sess_level = sl;
        @(negedge clk);
        vbus_upd = 1'b0; sess_upd = 1'b0;
        if (ve) m_vbus = vl;
        if (se) begin m_ok = sl; m_over = !sl; end
        check(vbus_chg_evt == exp_chg, tag, {31'h0, vbus_chg_evt}, {31'h0, exp_chg});
        @(negedge clk);
        check(vbus_chg_evt == 1'b0, "R4 pulse lasts one cycle",
              {31'h0, vbus_chg_evt}, 32'h0);
    endtask

    task automatic t_reset();
        check(vbus_chg_evt == 1'b0, "R1 event low after reset",
              {31'h0, vbus_chg_evt}, 32'h0);
        check(rd_data == 32'h0, "R1 read data zero after reset", rd_data, 32'h0);
        read_check("R1 word zero, ID bit 3 host role");
    endtask

    task automatic t_vbus_rise();
        apply(1'b1, 1'b1, 1'b0, 1'b0, "R4 event on VBUS rise");
        read_check("R2 VBUS bit set");
    endtask

    task automatic t_vbus_repeat();
        apply(1'b1, 1'b1, 1'b0, 1'b0, "R5 no event on repeated level");
        read_check("R5 word unchanged on repeat");
    endtask

    task automatic t_sess_on();
        apply(1'b0, 1'b0, 1'b1, 1'b1, "R7 session on raises nothing");
        read_check("R6 session valid set, end clear");
    endtask

    task automatic t_vbus_fall();
        apply(1'b1, 1'b0, 1'b0, 1'b0, "R4 event on VBUS fall");
        read_check("R3 VBUS bit cleared");
    endtask

    task automatic t_sess_off();
        apply(1'b0, 1'b0, 1'b1, 1'b0, "R7 session off raises nothing");
        read_check("R6 session end set, valid clear");
    endtask

    task automatic t_both();
        apply(1'b1, 1'b1, 1'b1, 1'b1, "R8 joint report toggles VBUS");
        read_check("R8 both reports applied");
        apply(1'b1, 1'b1, 1'b1, 1'b0, "R8 joint report, VBUS unchanged");
        read_check("R8 session flipped, VBUS kept");
    endtask

    task automatic t_read_timing();
        logic [31:0] old_w;
        old_w = model_word();
        // Read issued on the same edge as a VBUS toggle returns the old word.
        @(negedge clk);
        rd_en = 1'b1; vbus_upd = 1'b1; vbus_level = !m_vbus;
        @(negedge clk);
        rd_en = 1'b0; vbus_upd = 1'b0;
        m_vbus = !m_vbus;
        check(rd_data == old_w, "R10 read returns pre-update word", rd_data, old_w);
        check(vbus_chg_evt == 1'b1, "R4 event alongside read",
              {31'h0, vbus_chg_evt}, 32'h1);
        // With rd_en low, rd_data must hold across further updates.
        apply(1'b0, 1'b0, 1'b1, 1'b1, "R7 session on during hold");
        check(rd_data == old_w, "R10 read data holds", rd_data, old_w);
        read_check("R10 fresh read after hold");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_vbus_rise();
        t_vbus_repeat();
        t_sess_on();
        t_vbus_fall();
        t_sess_off();
        t_both();
        t_read_timing();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=5000 cycles", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule